// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

The block is a watchdog timer reached through a plain memory-mapped register port: a byte address, 32-bit write data, a write strobe and combinational read data. A slow tick input, one clock wide per tick, passes through a programmable prescaler. Each prescaled tick decrements a 16-bit down-counter while the timer is enabled. When the count runs out, a sticky reset request is raised toward the system. Only a block reset clears the request.

Each write must carry a fixed key in the upper half-word, or the write is dropped. The divisor and reload count that software writes are only staged. They reach the live prescaler and counter through a refresh handshake. The refresh register holds three 2-bit groups, and a group acts only when its code flips between 1 and 2. Software flips all three groups at once by XOR-ing the value it read back with 0x3F. This lets a stray write neither restart the count nor change the rate at which it runs down.

Top module: `wdt_keyed`

## Requirements
- R1: A write is accepted only when write-data bits 31:16 equal 0x1234; a write with any other key leaves every register, and so its readback, unchanged.
- R2: Reads return the stored 16-bit value in bits 15:0 with bits 31:16 zero, at byte offsets 0x04 (config), 0x08 (load), 0x18 (refresh) and 0x1C (start); any other offset reads zero.
- R3: After reset: config reads 0x0F00 (divisor 16), load reads 0xFFFF, refresh reads 0x0015, start reads 0 and the reset request is low.
- R4: Config bits 15:8 hold the divisor minus one (divisor 1..256); once it is made live, every divisor-th tick is a prescaled tick, counted from the refresh.
- R5: A 1↔2 flip of refresh bits 3:2 reloads the counter with the load value; a 1↔2 flip of bits 5:4 makes the config divisor live and restarts the prescaler.
- R6: A refresh group whose new code is 0 or 3, or that is unchanged, or that moves between 0/3 and 1/2, triggers nothing; a flip of bits 1:0 alone (interrupt group) leaves the counter and prescaler untouched.
- R7: Writing the config or load register without a refresh does not disturb a running count or its rate.
- R8: With start bit 0 set and load N ≥ 1 made live, the reset request rises on the N-th prescaled tick after the reload, i.e. after N×divisor ticks, and stays high until block reset, even if the timer is then stopped.
- R9: With start bit 0 clear, the prescaler and counter hold their values and no reset request is raised.
- R10: With a live load of 0, the request rises on the first prescaled tick after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| tick | input | 1 | One-clock pulse per slow tick |
| addr | input | 8 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Key in 31:16, register content in 15:0 |
| rd_data | output | 32 | Readback of the addressed register |
| rst_req | output | 1 | Sticky reset request |

## Verification
Wrong live state is hidden until the request pin moves. A bad prescaler phase or a bad live divisor shifts the tick on which rst_req rises. A missed or spurious reload moves that edge by whole prescaled periods. So each scenario counts ticks to the exact edge and checks that the request is low one tick before it and high on it. Register-file and key faults show at once on rd_data, in the cycle after the write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [15:0] WR_KEY = 16'h1234;
  localparam int DATA_W = 16;
  localparam int OFS_CFG   = 'h04;
  localparam int OFS_LOAD  = 'h08;
  localparam int OFS_REFR  = 'h18;
  localparam int OFS_START = 'h1C;
  localparam int NGRP    = 3;
  localparam int GRP_INT = 0;
  localparam int GRP_CNT = 1;
  localparam int GRP_CFG = 2;

  function automatic logic key_ok(logic [31:0] d);
    return d[31:16] == WR_KEY;
  endfunction

  function automatic logic grp_flip(logic [1:0] o, logic [1:0] n);
    return (o == 2'd1 && n == 2'd2) || (o == 2'd2 && n == 2'd1);
  endfunction

  function automatic logic [7:0] pre_next(logic [7:0] c, logic [7:0] lim);
    return (c == lim) ? 8'd0 : c + 8'd1;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs #(
  parameter int ADDR_W = 8,
  parameter int DEF_DIV = 16,
  parameter logic [15:0] RST_LOAD = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic [7:0]        cfg_div_m1,
  output logic [15:0]       load_val,
  output logic [5:0]        refr_old,
  output logic              refr_wr,
  output logic              run_en
);
  import wdt_pkg::*;
  localparam logic [15:0] CFG_RST = {8'(DEF_DIV - 1), 8'h00};

  logic [15:0] cfg_q, load_q, refr_q, start_q;
  logic wr_ok;
  assign wr_ok = wr_en && key_ok(wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RST;
      load_q  <= RST_LOAD;
      refr_q  <= 16'h0015;
      start_q <= 16'h0000;
    end else if (wr_ok) begin
      if (addr == ADDR_W'(OFS_CFG))   cfg_q   <= wr_data[15:0];
      if (addr == ADDR_W'(OFS_LOAD))  load_q  <= wr_data[15:0];
      if (addr == ADDR_W'(OFS_REFR))  refr_q  <= wr_data[15:0];
      if (addr == ADDR_W'(OFS_START)) start_q <= wr_data[15:0];
    end
  end

  always_comb begin
    rd_data = 32'd0;
    case (addr)
      ADDR_W'(OFS_CFG):   rd_data[15:0] = cfg_q;
      ADDR_W'(OFS_LOAD):  rd_data[15:0] = load_q;
      ADDR_W'(OFS_REFR):  rd_data[15:0] = refr_q;
      ADDR_W'(OFS_START): rd_data[15:0] = start_q;
      default:            rd_data = 32'd0;
    endcase
  end

  assign cfg_div_m1 = cfg_q[15:8];
  assign load_val   = load_q;
  assign refr_old   = refr_q[5:0];
  assign refr_wr    = wr_ok && (addr == ADDR_W'(OFS_REFR));
  assign run_en     = start_q[0];
endmodule

// File: rtl/wdt_refresh_det.sv
module wdt_refresh_det (
  input  logic       strobe,
  input  logic [5:0] old_val,
  input  logic [5:0] new_val,
  output logic [wdt_pkg::NGRP-1:0] evt
);
  import wdt_pkg::*;
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign evt[g] = strobe && grp_flip(old_val[2*g+1:2*g], new_val[2*g+1:2*g]);
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DEF_DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       restart,
  input  logic [7:0] div_m1_in,
  output logic [7:0] div_live,
  output logic       ptick
);
  import wdt_pkg::*;
  logic [7:0] pcnt;

  assign ptick = en && tick && !restart && (pcnt == div_live);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_live <= 8'(DEF_DIV - 1);
      pcnt     <= 8'd0;
    end else if (restart) begin
      div_live <= div_m1_in;
      pcnt     <= 8'd0;
    end else if (en && tick) begin
      pcnt <= pre_next(pcnt, div_live);
    end
  end
endmodule

// File: rtl/wdt_downcounter.sv
module wdt_downcounter #(
  parameter logic [15:0] RST_LOAD = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        ptick,
  input  logic        reload,
  input  logic [15:0] load_val,
  output logic [15:0] count,
  output logic        expire,
  output logic        req
);
  assign expire = en && ptick && !reload && (count <= 16'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= RST_LOAD;
      req   <= 1'b0;
    end else begin
      if (reload)
        count <= load_val;
      else if (en && ptick && count != 16'd0)
        count <= count - 16'd1;
      if (expire) req <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int ADDR_W = 8,
  parameter int DEF_DIV = 16,
  parameter logic [15:0] RST_LOAD = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              rst_req
);
  import wdt_pkg::*;

  logic [7:0]  cfg_div_m1, div_live;
  logic [15:0] load_val, count;
  logic [5:0]  refr_old;
  logic        refr_wr, run_en, ptick, expire;
  logic [NGRP-1:0] grp_evt;
  logic        cfg_evt, cnt_evt, int_evt;

  wdt_regs #(.ADDR_W(ADDR_W), .DEF_DIV(DEF_DIV), .RST_LOAD(RST_LOAD)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cfg_div_m1(cfg_div_m1), .load_val(load_val),
    .refr_old(refr_old), .refr_wr(refr_wr), .run_en(run_en)
  );

  wdt_refresh_det u_det (
    .strobe(refr_wr), .old_val(refr_old), .new_val(wr_data[5:0]), .evt(grp_evt)
  );

  assign cfg_evt = grp_evt[GRP_CFG];
  assign cnt_evt = grp_evt[GRP_CNT];
  assign int_evt = grp_evt[GRP_INT];

  wdt_prescaler #(.DEF_DIV(DEF_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(run_en), .tick(tick), .restart(cfg_evt),
    .div_m1_in(cfg_div_m1), .div_live(div_live), .ptick(ptick)
  );

  wdt_downcounter #(.RST_LOAD(RST_LOAD)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(run_en), .ptick(ptick), .reload(cnt_evt),
    .load_val(load_val), .count(count), .expire(expire), .req(rst_req)
  );
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        run_en,
  input logic        ptick,
  input logic        cfg_evt,
  input logic        cnt_evt,
  input logic [7:0]  div_live,
  input logic [15:0] count,
  input logic [15:0] load_val,
  input logic [31:0] rd_data,
  input logic        rst_req
);
  AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[31:16] != 16'h1234) |=> $stable(load_val) && $stable(run_en)); // R1
  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req); // R8
  AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(run_en)); // R9
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_evt) |=> $stable(count)); // R9
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_evt |=> count == $past(load_val)); // R5
  AST_DIV_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_evt |=> $stable(div_live)); // R7
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ptick && !cnt_evt && count != 16'd0) |=> count == $past(count) - 16'd1); // R8
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[31:16] == 16'd0); // R2
endmodule

bind wdt_keyed wdt_keyed_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .run_en(run_en),
  .ptick(ptick), .cfg_evt(cfg_evt), .cnt_evt(cnt_evt), .div_live(div_live),
  .count(count), .load_val(load_val), .rd_data(rd_data), .rst_req(rst_req)
);

// File: tb/wdt_keyed_bench.sv
module wdt_keyed_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] KEY = 16'h1234;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic rst_req;
  int checks = 0, errors = 0;

  wdt_keyed u_wdt_keyed (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .rst_req(rst_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] k, input logic [15:0] v);
    @(negedge clk); addr = a; wr_data = {k, v}; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rd_data;
  endtask

  task automatic refresh(input logic [5:0] mask);
    logic [31:0] v;
    rd(8'h18, v);
    wr(8'h18, KEY, v[15:0] ^ {10'd0, mask});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic setup_run(input logic [15:0] cfg, input logic [15:0] load);
    do_reset();
    wr(8'h04, KEY, cfg);
    wr(8'h08, KEY, load);
    refresh(6'h3F);
    wr(8'h1C, KEY, 16'h0001);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    rd(8'h04, v); chk("R3 cfg", v, 32'h0F00);
    rd(8'h08, v); chk("R3 load", v, 32'hFFFF);
    rd(8'h18, v); chk("R3 refresh", v, 32'h0015);
    rd(8'h1C, v); chk("R3 start", v, 32'h0);
    chk("R3 rst_req", {31'd0, rst_req}, 32'd0);
  endtask

  task automatic t_readback_key();
    logic [31:0] v;
    wr(8'h04, KEY, 16'h0100);
    rd(8'h04, v); chk("R2 cfg readback", v, 32'h0000_0100);
    wr(8'h08, KEY, 16'h0003);
    rd(8'h08, v); chk("R2 load readback", v, 32'h3);
    rd(8'h0C, v); chk("R2 unmapped", v, 32'h0);
    wr(8'h08, 16'h4321, 16'h5555);
    rd(8'h08, v); chk("R1 bad key load", v, 32'h3);
    wr(8'h1C, 16'h1235, 16'h0001);
    rd(8'h1C, v); chk("R1 bad key start", v, 32'h0);
  endtask

  task automatic t_expire_sticky();
    setup_run(16'h0100, 16'h0003);
    ticks(5); chk("R4 R8 before expiry", {31'd0, rst_req}, 32'd0);
    ticks(1); chk("R8 at N*D ticks", {31'd0, rst_req}, 32'd1);
    wr(8'h1C, KEY, 16'h0000);
    ticks(3); chk("R8 sticky", {31'd0, rst_req}, 32'd1);
    do_reset(); chk("R8 cleared by reset", {31'd0, rst_req}, 32'd0);
  endtask

  task automatic t_disabled();
    do_reset();
    wr(8'h04, KEY, 16'h0000);
    wr(8'h08, KEY, 16'h0002);
    refresh(6'h3F);
    ticks(5); chk("R9 stopped no request", {31'd0, rst_req}, 32'd0);
    wr(8'h1C, KEY, 16'h0001);
    ticks(1); chk("R9 count held", {31'd0, rst_req}, 32'd0);
    ticks(1); chk("R9 resumes", {31'd0, rst_req}, 32'd1);
  endtask

  task automatic t_no_disturb();
    setup_run(16'h0000, 16'h0004);
    ticks(2);
    wr(8'h08, KEY, 16'h0100);
    wr(8'h04, KEY, 16'hFF00);
    ticks(1); chk("R7 before", {31'd0, rst_req}, 32'd0);
    ticks(1); chk("R7 rate and count kept", {31'd0, rst_req}, 32'd1);
  endtask

  task automatic t_group_noaction();
    setup_run(16'h0000, 16'h0003);
    ticks(2);
    wr(8'h18, KEY, 16'h002E);
    wr(8'h18, KEY, 16'h002A);
    wr(8'h18, KEY, 16'h002A);
    ticks(1); chk("R6 codes 3/unchanged ignored", {31'd0, rst_req}, 32'd1);
    setup_run(16'h0000, 16'h0003);
    ticks(2);
    refresh(6'h03);
    ticks(1); chk("R6 int group no reload", {31'd0, rst_req}, 32'd1);
  endtask

  task automatic t_reload();
    setup_run(16'h0000, 16'h0003);
    ticks(2);
    refresh(6'h0C);
    ticks(2); chk("R5 reload before", {31'd0, rst_req}, 32'd0);
    ticks(1); chk("R5 reload expiry", {31'd0, rst_req}, 32'd1);
  endtask

  task automatic t_cfg_refresh();
    do_reset();
    wr(8'h04, KEY, 16'h0200);
    wr(8'h08, KEY, 16'h0002);
    refresh(6'h0C);
    wr(8'h1C, KEY, 16'h0001);
    ticks(31); chk("R5 default divisor still live", {31'd0, rst_req}, 32'd0);
    ticks(1); chk("R5 default divisor 16", {31'd0, rst_req}, 32'd1);
    do_reset();
    wr(8'h04, KEY, 16'h0200);
    wr(8'h08, KEY, 16'h0002);
    refresh(6'h3F);
    wr(8'h1C, KEY, 16'h0001);
    ticks(5); chk("R4 divisor 3 before", {31'd0, rst_req}, 32'd0);
    ticks(1); chk("R4 divisor 3", {31'd0, rst_req}, 32'd1);
  endtask

  task automatic t_load_zero();
    setup_run(16'h0000, 16'h0000);
    chk("R10 idle", {31'd0, rst_req}, 32'd0);
    ticks(1); chk("R10 first prescaled tick", {31'd0, rst_req}, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_readback_key();
    t_expire_sticky();
    t_disabled();
    t_no_disturb();
    t_group_noaction();
    t_reload();
    t_cfg_refresh();
    t_load_zero();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule